// File: doc/BRIEF.md
# Framed Four-Bit Pattern Recognizer

This block watches a serial stream, one bit per clock, and cuts it into back-to-back frames of four bits. No frame overlaps another. The output `match_o` is high during the cycle that carries the fourth bit of a frame, but only when that frame is `0110` or `1010`, counting the earliest bit first. It is a Mealy machine, so `match_o` depends on the present state and on the bit arriving in that same cycle. It is not registered.

The machine has seven states with fixed, hand-picked codes, and its state register is brought out on `state_o` so the encoding can be observed. The states are as follows. IDLE waits for the first bit of a frame. HEAD0 and HEAD1 mean the first bit was 0 or 1. LIVE2 means the first two bits can still lead to a match. DEAD2 means they cannot. LIVE3 means three bits could still match. DEAD3 means the frame has already failed.

The transitions are as follows. IDLE goes to HEAD0 on 0 and to HEAD1 on 1. HEAD0 goes to DEAD2 on 0 and to LIVE2 on 1. HEAD1 goes to LIVE2 on 0 and to DEAD2 on 1. DEAD2 goes to DEAD3 on either bit. LIVE2 goes to DEAD3 on 0 and to LIVE3 on 1. DEAD3 and LIVE3 go back to IDLE on either bit. A synchronous reset drops the machine into IDLE, and the first bit sampled after reset is released starts a new frame.

Top module: `frame4_recognizer`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the next state is IDLE (`state_o` = 000). `match_o` is 0 for as long as the state is IDLE.
- R2: The state codes on `state_o` are: IDLE=000, HEAD0=001, HEAD1=101, DEAD2=011, LIVE2=111, DEAD3=010, LIVE3=110. Code 100 never appears.
- R3: From IDLE, bit 0 leads to HEAD0 (001) and bit 1 leads to HEAD1 (101).
- R4: The second bit moves HEAD0 to DEAD2 on 0 and to LIVE2 on 1. It moves HEAD1 to LIVE2 on 0 and to DEAD2 on 1.
- R5: The third bit moves DEAD2 to DEAD3 on either value. It moves LIVE2 to DEAD3 on 0 and to LIVE3 on 1.
- R6: After the fourth bit of any frame, the state is IDLE (000), whatever the bits were. The first bit after reset is released is bit one of a frame, and a reset in the middle of a frame restarts framing.
- R7: `match_o` is 1 in the fourth-bit cycle of a frame whose bits, earliest first, are `0110` or `1010`.
- R8: `match_o` is 0 in the first, second and third bit cycles of every frame, and in the fourth-bit cycle of the other fourteen frame values.
- R9: `match_o` responds to the fourth bit within the same clock cycle, before the edge that samples that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; state advances on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| bit_i | input | 1 | Serial data bit for this cycle |
| match_o | output | 1 | High during the fourth bit of a matching frame |
| state_o | output | 3 | Present state code |

## Verification
The bench drives all sixteen four-bit frames in turn. A design that swapped the HEAD0 and HEAD1 branches, or that checked the wrong final bit, would flag the wrong frames or miss `0110` or `1010`. A long random stream exercises frame alignment: a design that failed to return to IDLE, or that allowed overlapping matches, would drift off the four-bit boundaries and report hits in the wrong cycles. Resets are applied in the middle of a frame to confirm that framing restarts cleanly. Because every fourth-bit cycle is sampled before the clock edge, a design that registered the output would show the hit one cycle late.

// File: rtl/frame4_pkg.sv
package frame4_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE  = 3'b000,
        ST_HEAD0 = 3'b001,
        ST_HEAD1 = 3'b101,
        ST_DEAD2 = 3'b011,
        ST_LIVE2 = 3'b111,
        ST_DEAD3 = 3'b010,
        ST_LIVE3 = 3'b110
    } frame4_state_e;

endpackage

// File: rtl/frame4_next.sv
module frame4_next
    import frame4_pkg::*;
(
    input  frame4_state_e cur_i,
    input  logic          bit_i,
    output frame4_state_e nxt_o
);

    // Transition table; the spare code 100 falls back to IDLE.
    always_comb begin
        unique case (cur_i)
            ST_IDLE:  nxt_o = bit_i ? ST_HEAD1 : ST_HEAD0;
            ST_HEAD0: nxt_o = bit_i ? ST_LIVE2 : ST_DEAD2;
            ST_HEAD1: nxt_o = bit_i ? ST_DEAD2 : ST_LIVE2;
            ST_DEAD2: nxt_o = ST_DEAD3;
            ST_LIVE2: nxt_o = bit_i ? ST_LIVE3 : ST_DEAD3;
            ST_DEAD3: nxt_o = ST_IDLE;
            ST_LIVE3: nxt_o = ST_IDLE;
            default:  nxt_o = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/frame4_out.sv
module frame4_out
    import frame4_pkg::*;
(
    input  frame4_state_e cur_i,
    input  logic          bit_i,
    output logic          match_o
);

    // Mealy output: only the last bit of a live frame can complete a match.
    always_comb begin
        unique case (cur_i)
            ST_LIVE3: match_o = ~bit_i;
            default:  match_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/frame4_recognizer.sv
module frame4_recognizer
    import frame4_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               bit_i,
    output logic               match_o,
    output logic [STATE_W-1:0] state_o
);

    frame4_state_e state_q;
    frame4_state_e state_d;

    frame4_next u_next (
        .cur_i (state_q),
        .bit_i (bit_i),
        .nxt_o (state_d)
    );

    frame4_out u_out (
        .cur_i   (state_q),
        .bit_i   (bit_i),
        .match_o (match_o)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

    // R1: reset lands in IDLE with the output low
    a_r1_reset_idle: assert property (@(posedge clk_i)
        rst_i |=> (state_o == 3'b000 && !match_o));

    // R2: spare code never reached
    a_r2_no_spare_code: assert property (@(posedge clk_i) disable iff (rst_i)
        state_o != 3'b100);

    // R3: a frame's first bit leaves IDLE for a head state
    a_r3_leave_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_IDLE) |=> (state_q == ST_HEAD0 || state_q == ST_HEAD1));

    // R4: second bit reaches a depth-two state
    a_r4_depth_two: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_HEAD0 || state_q == ST_HEAD1) |=>
        (state_q == ST_DEAD2 || state_q == ST_LIVE2));

    // R5: third bit reaches a depth-three state
    a_r5_depth_three: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_DEAD2 || state_q == ST_LIVE2) |=>
        (state_q == ST_DEAD3 || state_q == ST_LIVE3));

    // R6: frame closes back to IDLE
    a_r6_frame_close: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_DEAD3 || state_q == ST_LIVE3) |=> (state_q == ST_IDLE));

    // R7: a hit follows a LIVE2 cycle that saw a 1
    a_r7_hit_history: assert property (@(posedge clk_i) disable iff (rst_i)
        match_o |-> ($past(state_q) == ST_LIVE2 && $past(bit_i)));

    // R8: no hit before the fourth bit
    a_r8_quiet_early: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q != ST_LIVE3 && state_q != ST_DEAD3) |-> !match_o);

endmodule

// File: tb/tb_frame4_recognizer.sv
module tb_frame4_recognizer;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 50000;

    typedef struct {
        logic       exp_hit;
        logic [2:0] exp_state;
        string      st_req;
        string      hit_req;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_in = 1'b0;
    logic       match;
    logic [2:0] state;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    exp_item_t sb_q[$];

    // Reference frame model
    int       pos = 0;
    logic [2:0] prefix = 3'b000;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame4_recognizer dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .bit_i   (bit_in),
        .match_o (match),
        .state_o (state)
    );

    // Expected state from the bits seen so far in the frame (R2..R6)
    function automatic logic [2:0] exp_state_f(int p, logic [2:0] pre);
        case (p)
            0: return 3'b000;
            1: return pre[0] ? 3'b101 : 3'b001;
            2: return (pre[1:0] == 2'b01 || pre[1:0] == 2'b10) ? 3'b111 : 3'b011;
            default: return (pre == 3'b011 || pre == 3'b101) ? 3'b110 : 3'b010;
        endcase
    endfunction

    task automatic drive_bit(input logic b);
        exp_item_t it;
        @(negedge clk);
        rst = 1'b0;
        bit_in = b;
        it.exp_state = exp_state_f(pos, prefix);
        it.exp_hit = (pos == 3) && ({prefix, b} == 4'b0110 || {prefix, b} == 4'b1010);
        case (pos)
            0: it.st_req = "R6 frame start";
            1: it.st_req = "R3 first bit";
            2: it.st_req = "R4 second bit";
            default: it.st_req = "R5 third bit";
        endcase
        if (pos == 3)
            it.hit_req = it.exp_hit ? "R7/R9 match" : "R8 fourth bit";
        else
            it.hit_req = "R8 early bit";
        sb_q.push_back(it);
        if (pos == 3) begin
            pos = 0;
            prefix = 3'b000;
        end else begin
            prefix = {prefix[1:0], b};
            pos = pos + 1;
        end
    endtask

    task automatic do_reset();
        exp_item_t it;
        @(negedge clk);
        rst = 1'b1;
        bit_in = 1'b1;
        @(negedge clk);
        it.exp_state = 3'b000;
        it.exp_hit = 1'b0;
        it.st_req = "R1 reset";
        it.hit_req = "R1 reset";
        sb_q.push_back(it);
        pos = 0;
        prefix = 3'b000;
    endtask

    task automatic drive_frame(input logic [3:0] f);
        for (int i = 3; i >= 0; i--) drive_bit(f[i]);
    endtask

    // Monitor: compare a quarter period after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (state !== it.exp_state) begin
                    fails++;
                    $display("FAIL %s (R2 codes): state=%b expected=%b", it.st_req, state, it.exp_state);
                end
                checks++;
                if (match !== it.exp_hit) begin
                    fails++;
                    $display("FAIL %s: match=%b expected=%b", it.hit_req, match, it.exp_hit);
                end
            end
        end
    end

    initial begin
        do_reset();
        // every frame value, earliest bit is the MSB
        for (int f = 0; f < 16; f++) drive_frame(f[3:0]);
        // both matches back to back, then a near miss
        drive_frame(4'b0110);
        drive_frame(4'b1010);
        drive_frame(4'b0111);
        // R6: reset in mid frame restarts framing
        drive_bit(1'b0);
        drive_bit(1'b1);
        do_reset();
        drive_frame(4'b1010);
        drive_bit(1'b1);
        do_reset();
        drive_frame(4'b0110);
        // random stream
        for (int i = 0; i < 800; i++) drive_bit(1'($urandom_range(0, 1)));
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, cycles=%0d expected below %0d", WATCHDOG_CYCLES, WATCHDOG_CYCLES);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule